// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is the master side of a byte-wide configuration port on a slave FPGA. On a start request it runs the full power-up sequence. It pulses the active-low program line and waits for the device to pull its init line low, then high again. Next it selects the device for writing and waits a settling time. After that it moves a stream of bytes from a valid/ready source onto the data bus, giving each byte one low-then-high cycle of a configuration clock it generates itself. After the last byte it deselects the device and waits for the done line to confirm that configuration succeeded.

Each phase has its own timeout, counted in system-clock cycles. A device that does not answer in time, a busy line that stays high, or an init line that drops during the transfer ends the run with an error code, and the port lines return to their inactive levels. A second mode reads bytes back: it selects the device with the write line high, clocks it once per byte, samples the bus, and finishes with one extra clock after deselecting the device.

The controller is a single state machine. Its states are IDLE, PROG, INIT_WAIT, SETTLE, FETCH, CLK_LO, CLK_HI, BUSY_WAIT, REL_CS, DONE_WAIT, RB_SEL, RB_LO, RB_HI, RB_END_LO and RB_END_HI.

The transitions are:
- IDLE to PROG, or to RB_SEL in readback mode, on start.
- PROG to INIT_WAIT once the minimum pulse has elapsed and init is low.
- INIT_WAIT to SETTLE when init goes high.
- SETTLE to FETCH when the settling time ends.
- FETCH to CLK_LO when a byte is accepted, or to REL_CS when the count is used up.
- CLK_LO to CLK_HI, then to FETCH, or to BUSY_WAIT when busy checking is on.
- BUSY_WAIT to FETCH when busy goes low.
- REL_CS to DONE_WAIT.
- DONE_WAIT to IDLE when done and init are both high.
- RB_SEL to RB_LO to RB_HI, looping back to RB_LO once per byte.
- RB_HI to RB_END_LO to RB_END_HI to IDLE.
- Every timeout and the init-drop check go straight to IDLE.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset: prog_n, cs_n, wr_n and cclk are 1; s_ready, rd_valid and op_done are 0; err_code is 0.
- R2: A load start holds prog_n low for at least PULSE_CYC cycles and until init_n is seen low. If init_n is not low within INIT_TO cycles, the run ends with err_code 1.
- R3: After prog_n is released, with cclk high, the block waits for init_n to go high. If that does not happen within INIT_TO cycles, the run ends with err_code 2.
- R4: Once init_n is high, cs_n and wr_n go low together, and s_ready stays low for at least SETTLE_CYC cycles after that.
- R5: Exactly byte_count bytes are taken, one per cycle in which s_valid and s_ready are both high. Each accepted byte is driven on d_out, then cclk is low for HALF_CYC cycles and high for HALF_CYC cycles. The device captures the byte on that rise, and d_out is unchanged for at least one cycle before it.
- R6: If init_n is low when the next byte would be fetched, the run ends with err_code 4.
- R7: With busy_chk_en high, after each clock-high phase the block waits for busy to be low, and ends with err_code 3 after BUSY_TO cycles. With busy_chk_en low, busy has no effect.
- R8: After the last byte, cs_n returns high one cycle before wr_n. The run succeeds when done and init_n are both high, and ends with err_code 5 if they are not within DONE_TO cycles.
- R9: In readback mode (read_mode=1), cs_n goes low with cclk high and wr_n high. For each of byte_count bytes there is a low and a high half-period, and d_in is sampled at the end of the high half and presented as rd_data with a one-cycle rd_valid. cs_n then returns high and one further low-then-high clock follows before success.
- R10: Every run ends with a one-cycle op_done pulse. op_ok and err_code hold their result until the next start. On an error, prog_n, cs_n and wr_n are all high, and op_ok=1 only with err_code 0.
- R11: start is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled in IDLE only) |
| read_mode | input | 1 | 0 = load, 1 = readback |
| byte_count | input | CNT_W | Number of bytes to move |
| busy_chk_en | input | 1 | Wait on busy after each clock pulse |
| s_valid | input | 1 | Source byte available |
| s_data | input | DATA_W | Source byte |
| s_ready | output | 1 | Byte accepted this cycle when s_valid is high |
| rd_valid | output | 1 | Readback byte strobe |
| rd_data | output | DATA_W | Readback byte |
| prog_n | output | 1 | Device program line, active low |
| init_n | input | 1 | Device init line |
| cs_n | output | 1 | Device chip select, active low |
| wr_n | output | 1 | Device write select, active low |
| cclk | output | 1 | Configuration clock |
| d_out | output | DATA_W | Byte driven to the device |
| d_in | input | DATA_W | Byte read from the device |
| busy | input | 1 | Device busy line |
| done | input | 1 | Device done line |
| op_done | output | 1 | One-cycle end-of-run pulse |
| op_ok | output | 1 | Last run succeeded |
| err_code | output | 3 | 0 none, 1 init-assert timeout, 2 init-release timeout, 3 busy timeout, 4 init fell, 5 done timeout |

## Verification
The pin levels are decoded directly from the state register. A machine stuck in or skipping a state therefore shows in the same cycle as a wrong combination of prog_n, cs_n, wr_n and cclk. Examples are s_ready outside a write selection, or wr_n rising before cs_n. A miscounted phase timer or byte counter shows one half-period later as a cclk edge at the wrong cycle, or as a missing or extra byte at the device model. A wrong exit decision shows by the end of the run, through op_done, op_ok and err_code. The fault vectors force each timeout path and check the code it reports.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_INIT_WAIT,
        ST_SETTLE,
        ST_FETCH,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_BUSY_WAIT,
        ST_REL_CS,
        ST_DONE_WAIT,
        ST_RB_SEL,
        ST_RB_LO,
        ST_RB_HI,
        ST_RB_END_LO,
        ST_RB_END_HI
    } ld_state_t;

    typedef enum logic [2:0] {
        ERR_NONE         = 3'd0,
        ERR_INIT_ASSERT  = 3'd1,
        ERR_INIT_RELEASE = 3'd2,
        ERR_BUSY         = 3'd3,
        ERR_INIT_FELL    = 3'd4,
        ERR_DONE         = 3'd5
    } ld_err_t;

endpackage

// File: rtl/cfgld_timer.sv
// Phase timer: counts cycles since the last clear, saturating at all ones.
module cfgld_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (count != '1) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/cfgld_bytecnt.sv
// Remaining-byte counter with zero and one flags.
module cfgld_bytecnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero,
    output logic         last
);
    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign zero = (remain == '0);
    assign last = (remain == W'(1));
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 16,
    parameter int PULSE_CYC  = 30,
    parameter int INIT_TO    = 50_000_000,
    parameter int SETTLE_CYC = 1_000_000,
    parameter int HALF_CYC   = 2,
    parameter int BUSY_TO    = 500_000,
    parameter int DONE_TO    = 20_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              read_mode,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              busy_chk_en,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              prog_n,
    input  logic              init_n,
    output logic              cs_n,
    output logic              wr_n,
    output logic              cclk,
    output logic [DATA_W-1:0] d_out,
    input  logic [DATA_W-1:0] d_in,
    input  logic              busy,
    input  logic              done,
    output logic              op_done,
    output logic              op_ok,
    output logic [2:0]        err_code
);
    function automatic int cyc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAX_CYC = cyc_max(cyc_max(cyc_max(INIT_TO, SETTLE_CYC),
                                             cyc_max(BUSY_TO, DONE_TO)),
                                     cyc_max(PULSE_CYC, HALF_CYC));
    localparam int TW = $clog2(MAX_CYC + 1) + 1;

    localparam logic [TW-1:0] T_PULSE  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] T_INIT   = TW'(INIT_TO - 1);
    localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] T_HALF   = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] T_BUSY   = TW'(BUSY_TO - 1);
    localparam logic [TW-1:0] T_DONE   = TW'(DONE_TO - 1);

    ld_state_t      state_q, state_d;
    ld_err_t        err_q, fin_err;
    logic           fin, fin_ok;
    logic [TW-1:0]  tmr;
    logic           half_end, cnt_zero, cnt_last, accept, rb_take, launch;

    assign half_end = (tmr == T_HALF);
    assign launch   = (state_q == ST_IDLE) && start;
    assign s_ready  = (state_q == ST_FETCH) && init_n && !cnt_zero;
    assign accept   = s_ready && s_valid;
    assign rb_take  = (state_q == ST_RB_HI) && half_end;
    assign err_code = err_q;

    cfgld_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .count (tmr)
    );

    cfgld_bytecnt #(.W(CNT_W)) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (byte_count),
        .dec      (accept || rb_take),
        .zero     (cnt_zero),
        .last     (cnt_last)
    );

    // Next state and end-of-run decision
    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        fin_ok  = 1'b0;
        fin_err = ERR_NONE;
        unique case (state_q)
            ST_IDLE:
                if (start) state_d = read_mode ? ST_RB_SEL : ST_PROG;
            ST_PROG:
                if (tmr >= T_PULSE && !init_n) begin
                    state_d = ST_INIT_WAIT;
                end else if (tmr == T_INIT) begin
                    state_d = ST_IDLE; fin = 1'b1; fin_err = ERR_INIT_ASSERT;
                end
            ST_INIT_WAIT:
                if (init_n) begin
                    state_d = ST_SETTLE;
                end else if (tmr == T_INIT) begin
                    state_d = ST_IDLE; fin = 1'b1; fin_err = ERR_INIT_RELEASE;
                end
            ST_SETTLE:
                if (tmr == T_SETTLE) state_d = ST_FETCH;
            ST_FETCH:
                if (!init_n) begin
                    state_d = ST_IDLE; fin = 1'b1; fin_err = ERR_INIT_FELL;
                end else if (cnt_zero) begin
                    state_d = ST_REL_CS;
                end else if (s_valid) begin
                    state_d = ST_CLK_LO;
                end
            ST_CLK_LO:
                if (half_end) state_d = ST_CLK_HI;
            ST_CLK_HI:
                if (half_end) state_d = busy_chk_en ? ST_BUSY_WAIT : ST_FETCH;
            ST_BUSY_WAIT:
                if (!busy) begin
                    state_d = ST_FETCH;
                end else if (tmr == T_BUSY) begin
                    state_d = ST_IDLE; fin = 1'b1; fin_err = ERR_BUSY;
                end
            ST_REL_CS:
                state_d = ST_DONE_WAIT;
            ST_DONE_WAIT:
                if (done && init_n) begin
                    state_d = ST_IDLE; fin = 1'b1; fin_ok = 1'b1;
                end else if (tmr == T_DONE) begin
                    state_d = ST_IDLE; fin = 1'b1; fin_err = ERR_DONE;
                end
            ST_RB_SEL:
                if (half_end) state_d = cnt_zero ? ST_RB_END_LO : ST_RB_LO;
            ST_RB_LO:
                if (half_end) state_d = ST_RB_HI;
            ST_RB_HI:
                if (half_end) state_d = cnt_last ? ST_RB_END_LO : ST_RB_LO;
            ST_RB_END_LO:
                if (half_end) state_d = ST_RB_END_HI;
            ST_RB_END_HI:
                if (half_end) begin
                    state_d = ST_IDLE; fin = 1'b1; fin_ok = 1'b1;
                end
            default:
                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Device pin levels per state
    always_comb begin
        prog_n = 1'b1;
        cs_n   = 1'b1;
        wr_n   = 1'b1;
        cclk   = 1'b1;
        unique case (state_q)
            ST_PROG:                                  prog_n = 1'b0;
            ST_SETTLE, ST_FETCH, ST_CLK_HI, ST_BUSY_WAIT: begin
                cs_n = 1'b0; wr_n = 1'b0;
            end
            ST_CLK_LO: begin
                cs_n = 1'b0; wr_n = 1'b0; cclk = 1'b0;
            end
            ST_REL_CS:                                wr_n = 1'b0;
            ST_RB_SEL, ST_RB_HI:                      cs_n = 1'b0;
            ST_RB_LO: begin
                cs_n = 1'b0; cclk = 1'b0;
            end
            ST_RB_END_LO:                             cclk = 1'b0;
            default: ;
        endcase
    end

    // Registered data and result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_out    <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
            op_done  <= 1'b0;
            op_ok    <= 1'b0;
            err_q    <= ERR_NONE;
        end else begin
            rd_valid <= rb_take;
            op_done  <= fin;
            if (accept)  d_out   <= s_data;
            if (rb_take) rd_data <= d_in;
            if (launch) begin
                op_ok <= 1'b0;
                err_q <= ERR_NONE;
            end else if (fin) begin
                op_ok <= fin_ok;
                err_q <= fin_err;
            end
        end
    end
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_n,
    input logic          cs_n,
    input logic          wr_n,
    input logic          cclk,
    input logic          s_ready,
    input logic [DW-1:0] d_out,
    input logic          op_done,
    input logic          op_ok,
    input logic [2:0]    err_code
);
    AST_PROG_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (cs_n && wr_n));                                         // R2
    AST_READY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (!cs_n && !wr_n && cclk));                              // R5
    AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cclk) && !wr_n) |-> $stable(d_out));                         // R5
    AST_CS_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> cs_n);                                              // R8
    AST_FAIL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_ok) |-> (cs_n && wr_n && prog_n && err_code != 3'd0)); // R10
    AST_OK_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_ok) |-> (err_code == 3'd0));                         // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);                                              // R10
endmodule

bind fpga_cfg_loader cfgld_checker #(.DW(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_n   (prog_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .cclk     (cclk),
    .s_ready  (s_ready),
    .d_out    (d_out),
    .op_done  (op_done),
    .op_ok    (op_ok),
    .err_code (err_code)
);

// File: tb/fpga_cfg_loader_test.sv
module fpga_cfg_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE = 6, INITTO = 40, SETTLE = 10, HALF = 2, BUSYTO = 20, DONETO = 30;

    typedef struct packed {
        logic       rd;
        logic [7:0] n;
        logic [2:0] flt;   // 0 none,1 init never low,2 init never high,3 init falls,4 busy stuck,5 no done
        logic       bchk;
        logic       bp;    // busy pulses after each capture
        logic       ok;
        logic [2:0] err;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd4, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0},
        '{1'b0, 8'd5, 3'd0, 1'b1, 1'b1, 1'b1, 3'd0},
        '{1'b0, 8'd3, 3'd1, 1'b0, 1'b0, 1'b0, 3'd1},
        '{1'b0, 8'd3, 3'd2, 1'b0, 1'b0, 1'b0, 3'd2},
        '{1'b0, 8'd6, 3'd3, 1'b0, 1'b0, 1'b0, 3'd4},
        '{1'b0, 8'd3, 3'd4, 1'b1, 1'b0, 1'b0, 3'd3},
        '{1'b0, 8'd4, 3'd5, 1'b0, 1'b0, 1'b0, 3'd5},
        '{1'b1, 8'd4, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0},
        '{1'b0, 8'd0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0},
        '{1'b1, 8'd1, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0},
        '{1'b0, 8'd4, 3'd4, 1'b0, 1'b0, 1'b1, 3'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, read_mode = 1'b0, busy_chk_en = 1'b0;
    logic [7:0] byte_count = '0;
    logic s_valid = 1'b0, busy = 1'b0, done = 1'b0, init_n = 1'b1;
    logic [7:0] s_data = '0, d_in = '0;
    logic s_ready, rd_valid, prog_n, cs_n, wr_n, cclk, op_done, op_ok;
    logic [7:0] rd_data, d_out;
    logic [2:0] err_code;

    fpga_cfg_loader #(.DATA_W(8), .CNT_W(8), .PULSE_CYC(PULSE), .INIT_TO(INITTO),
        .SETTLE_CYC(SETTLE), .HALF_CYC(HALF), .BUSY_TO(BUSYTO), .DONE_TO(DONETO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .read_mode(read_mode),
        .byte_count(byte_count), .busy_chk_en(busy_chk_en), .s_valid(s_valid),
        .s_data(s_data), .s_ready(s_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .prog_n(prog_n), .init_n(init_n), .cs_n(cs_n), .wr_n(wr_n), .cclk(cclk),
        .d_out(d_out), .d_in(d_in), .busy(busy), .done(done), .op_done(op_done),
        .op_ok(op_ok), .err_code(err_code));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0, n_fail = 0, wd = 0;

    // model configuration (written by tasks after posedge, read at negedge)
    logic       mdl_clr = 1'b0;
    logic [2:0] m_flt = '0;
    logic       m_bp = 1'b0;
    int         m_n = 0;

    // model state (negedge process only)
    logic [7:0] cap [64];
    logic [7:0] rbq [64];
    int ncap = 0, rb_n = 0, rb_idx = 0, rb_tail = 0, sidx = 0, cyc = 0;
    int prog_cnt = 0, prog_meas = 0, rel_cnt = -1, settle_cnt = 0, settle_meas = -1;
    int busy_cnt = 0, done_pulses = 0;
    logic pend = 1'b0, cfg_started = 1'b0, stab_err = 1'b0, order_seen = 1'b0;
    logic first_ready = 1'b0, cclk_prev = 1'b1;
    logic [7:0] dprev = '0;

    function automatic logic [7:0] src_byte(input int i);
        return 8'hA5 ^ 8'(i * 29);
    endfunction
    function automatic logic [7:0] rb_byte(input int i);
        return 8'(i * 7 + 3);
    endfunction

    always @(negedge clk) begin
        if (mdl_clr) begin
            ncap = 0; rb_n = 0; rb_idx = 0; rb_tail = 0; sidx = 0; pend = 1'b0;
            prog_cnt = 0; prog_meas = 0; rel_cnt = -1; settle_cnt = 0; settle_meas = -1;
            busy_cnt = 0; done_pulses = 0; cfg_started = 1'b0; stab_err = 1'b0;
            order_seen = 1'b0; first_ready = 1'b0;
            init_n = 1'b1; busy = 1'b0; done = 1'b0;
        end else if (rst_n) begin
            if (!prog_n) begin
                prog_cnt++;
                if (prog_cnt >= 2 && m_flt != 3'd1) init_n = 1'b0;
                done = 1'b0; busy = 1'b0; cfg_started = 1'b0;
            end else if (prog_cnt != 0) begin
                prog_meas = prog_cnt; prog_cnt = 0; rel_cnt = 0;
            end
            if (rel_cnt >= 0) begin
                rel_cnt++;
                if (rel_cnt == 5) begin
                    if (m_flt != 3'd2) begin init_n = 1'b1; cfg_started = 1'b1; end
                    rel_cnt = -1;
                end
            end
            if (busy_cnt > 0) begin busy = 1'b1; busy_cnt--; end
            else if (!(m_flt == 3'd4 && ncap > 0)) busy = 1'b0;
            if (cclk && !cclk_prev) begin
                if (!cs_n && !wr_n) begin
                    if (d_out != dprev) stab_err = 1'b1;
                    cap[ncap] = d_out; ncap++;
                    if (m_bp) busy_cnt = 3;
                    if (m_flt == 3'd4) busy = 1'b1;
                    if (m_flt == 3'd3 && ncap == 2) init_n = 1'b0;
                end else if (!cs_n && wr_n) begin
                    d_in = rb_byte(rb_idx); rb_idx++;
                end else if (cs_n) begin
                    rb_tail++;
                end
            end
            if (cs_n && !wr_n) order_seen = 1'b1;
            if (!cs_n && !wr_n && !first_ready) begin
                if (s_ready) begin first_ready = 1'b1; settle_meas = settle_cnt; end
                else settle_cnt++;
            end
            done = cfg_started && (ncap == m_n) && (m_flt != 3'd5) && init_n;
            if (pend) sidx++;
            s_data  = src_byte(sidx);
            s_valid = (sidx < m_n) && ((cyc % 4) != 1);
            pend    = s_valid && s_ready;
            if (rd_valid) begin rbq[rb_n] = rd_data; rb_n++; end
            if (op_done) done_pulses++;
        end
        dprev = d_out; cclk_prev = cclk; cyc++;
    end

    task automatic chk(input logic cond, input string tag, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string err_tag(input vec_t v);
        case (v.err)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R7";
            3'd4: return "R6";
            3'd5: return "R8";
            default: return v.rd ? "R9" : "R8";
        endcase
    endfunction

    task automatic run_vec(input vec_t v, input int extra_start_at);
        int waited;
        logic seen;
        @(posedge clk); #1;
        mdl_clr = 1'b1; m_flt = v.flt; m_bp = v.bp; m_n = int'(v.n);
        @(posedge clk); #1;
        mdl_clr = 1'b0;
        read_mode = v.rd; byte_count = v.n; busy_chk_en = v.bchk; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        waited = 0; seen = 1'b0;
        while (!seen && waited < 3000) begin
            @(negedge clk);
            waited++;
            if (waited == extra_start_at) begin read_mode = 1'b1; start = 1'b1; end
            if (waited == extra_start_at + 1) start = 1'b0;
            if (op_done) seen = 1'b1;
        end
        chk(seen, "R10 op_done seen", int'(seen), 1);
        chk(op_ok == v.ok, err_tag(v), int'(op_ok), int'(v.ok));
        chk(err_code == v.err, err_tag(v), int'(err_code), int'(v.err));
        repeat (6) @(posedge clk);
        #1;
        chk(err_code == v.err && op_ok == v.ok, "R10 result held", int'(err_code), int'(v.err));
        chk(done_pulses == 1, "R10 single op_done", done_pulses, 1);
        if (!v.ok) begin
            chk(cs_n && wr_n && prog_n, "R10 pins released on error",
                int'({prog_n, cs_n, wr_n}), 7);
        end else if (!v.rd) begin
            chk(ncap == int'(v.n), "R5 byte count captured", ncap, int'(v.n));
            chk(sidx == int'(v.n), "R5 bytes accepted", sidx, int'(v.n));
            for (int i = 0; i < int'(v.n); i++)
                chk(cap[i] == src_byte(i), "R5 byte value", int'(cap[i]), int'(src_byte(i)));
            chk(!stab_err, "R5 data stable before rise", int'(stab_err), 0);
            chk(prog_meas >= PULSE, "R2 program pulse width", prog_meas, PULSE);
            chk(order_seen, "R8 cs released before wr", int'(order_seen), 1);
            if (v.n != 0) chk(settle_meas >= SETTLE, "R4 settle time", settle_meas, SETTLE);
        end else begin
            chk(rb_n == int'(v.n), "R9 readback count", rb_n, int'(v.n));
            for (int i = 0; i < int'(v.n) && i < rb_n; i++)
                chk(rbq[i] == rb_byte(i), "R9 readback value", int'(rbq[i]), int'(rb_byte(i)));
            chk(rb_tail == 1, "R9 trailing clock", rb_tail, 1);
            chk(ncap == 0, "R9 no write capture", ncap, 0);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(prog_n && cs_n && wr_n && cclk, "R1 pins idle", int'({prog_n, cs_n, wr_n, cclk}), 15);
        chk(!s_ready && !rd_valid && !op_done, "R1 strobes low",
            int'({s_ready, rd_valid, op_done}), 0);
        chk(err_code == 3'd0, "R1 error code", int'(err_code), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(prog_n && cs_n && wr_n && cclk, "R1 idle after release",
            int'({prog_n, cs_n, wr_n, cclk}), 15);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], -1);

        // R11: a second start in mid-load (asking for readback) is ignored
        run_vec('{1'b0, 8'd6, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0}, 30);
        // R11: back-to-back run after the ignored start behaves normally
        run_vec('{1'b0, 8'd2, 3'd0, 1'b1, 1'b1, 1'b1, 3'd0}, -1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule